// File: doc/BRIEF.md
# Special-Purpose Register Access Checker

This block judges every move-to or move-from special-purpose register request. For each request it picks one of three outcomes: the access executes, it retires as a no-op, or it raises a hypervisor emulation-assistance interrupt. The inputs to that decision are the SPR number, the transfer direction, the current privilege state (user, supervisor or hypervisor) and a virtualization-control bit. A combinational table lists the implemented SPR numbers, with read and write permission for each privilege level and a flag for registers whose value can change before the instruction completes. The table drives the decision.

The verdict is held in a small state machine, and the registered outputs are decoded from that state. The outputs are the interrupt request, the destination general-register write enable, and a flag that allows the read result onto the early bypass path. A separate combinational gate produces the external-interrupt valid signal from the pending and enable inputs, the privilege state and a hypervisor-only external-interrupt disable bit. SPR storage itself lives elsewhere.

State machine. The states are `ST_IDLE`, `ST_RD_FWD`, `ST_RD_LATE`, `ST_WR_DONE`, `ST_NOP` and `ST_TRAP`. Every state takes its next state from the current inputs alone:
- Any state goes to `ST_IDLE` when `stall` is high or `req_valid` is low.
- Otherwise the accepted request selects the next state:
  - An executed read of a fast register goes to `ST_RD_FWD`.
  - An executed read of a slow or performance-monitor register goes to `ST_RD_LATE`.
  - An executed write goes to `ST_WR_DONE`.
  - A no-op verdict goes to `ST_NOP`.
  - A trap verdict goes to `ST_TRAP`.

Top module: `spr_access_check`

## Requirements
- R1: After reset deasserts, `hv_emul_irq`, `gpr_wr_en` and `fwd_allow` are all 0.
- R2: The verdict for a request accepted at a rising edge shows on the outputs right after that edge, for one cycle. A cycle with `req_valid` low leaves all three outputs at 0 in the following cycle.
- R3: A request presented while `stall` is 1 produces no interrupt, no write enable and no forward in the following cycle.
- R4: In supervisor or hypervisor state, any access to SPR 0, 4, 5 or 6, in either direction, raises `hv_emul_irq`.
- R5: In user state, any access that the table does not permit for user state in that direction raises `hv_emul_irq`.
- R6: In hypervisor state, an access that the table does not permit raises `hv_emul_irq` when `virt_trap_en` is 1. It is a no-op (all outputs 0) when `virt_trap_en` is 0.
- R7: In supervisor state, a non-reserved access that the table does not permit is a no-op.
- R8: An executed read asserts `gpr_wr_en`. A no-op read leaves it at 0, and so does every write.
- R9: `fwd_allow` is 1 only for an executed read of a fast register. It stays 0 for the slow registers 22 and 268 and for the performance-monitor range 776 to 783.
- R10: `ext_irq_valid` = `ext_irq_pending` AND `ext_irq_enable` AND NOT(`ext_irq_hv_dis` AND hypervisor state). The disable bit therefore has no effect in user or supervisor state.
- R11: The privilege encoding is 00 user, 01 supervisor, and 10 or 11 hypervisor. The permission table is as follows:
  - SPRs 1, 8 and 9 are readable and writable at every level.
  - SPR 268 is readable at every level and writable at none.
  - SPRs 22, 26 and 27 are readable and writable in supervisor and hypervisor state.
  - SPR 304 is readable and writable in hypervisor state only.
  - SPRs 776 to 783 are readable at every level and writable in supervisor and hypervisor state.
  - All other numbers are undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_is_write | input | 1 | 1 = move to SPR, 0 = move from SPR |
| req_spr | input | 10 | SPR number |
| priv_mode | input | 2 | Privilege state (R11 encoding) |
| virt_trap_en | input | 1 | Trap undefined SPRs in hypervisor state |
| stall | input | 1 | Pipeline stall; suppresses the verdict |
| ext_irq_pending | input | 1 | External interrupt pending |
| ext_irq_enable | input | 1 | External interrupts enabled |
| ext_irq_hv_dis | input | 1 | Disable external interrupts in hypervisor state |
| hv_emul_irq | output | 1 | Hypervisor emulation-assistance interrupt request |
| gpr_wr_en | output | 1 | Destination general-register write enable |
| fwd_allow | output | 1 | Read result may use the early bypass |
| ext_irq_valid | output | 1 | External interrupt may be taken |

## Verification
The interrupt, write-enable and forward outputs are due one cycle after the request: they come from a state register loaded at the rising edge that samples the request. The driver applies each request at a falling edge and queues its expected verdict at the same time. The monitor pops exactly one item per rising edge and compares it 5 ns after that edge, so the comparison always lands in the cycle the verdict belongs to. `ext_irq_valid` is combinational, so the driver checks it 1 ns after it changes the inputs, in the same cycle.

// File: rtl/spr_chk_pkg.sv
package spr_chk_pkg;

    localparam int SPR_FIXUP  = 1;
    localparam int SPR_LINK   = 8;
    localparam int SPR_COUNT  = 9;
    localparam int SPR_DECR   = 22;
    localparam int SPR_SAVE0  = 26;
    localparam int SPR_SAVE1  = 27;
    localparam int SPR_TBASE  = 268;
    localparam int SPR_HSCR   = 304;

    typedef struct packed {
        logic defined;
        logic rd_user;
        logic wr_user;
        logic rd_sup;
        logic wr_sup;
        logic rd_hyp;
        logic wr_hyp;
        logic slow;
        logic pmu;
    } spr_attr_t;

    typedef enum logic [1:0] {
        OUT_EXEC = 2'd0,
        OUT_NOP  = 2'd1,
        OUT_TRAP = 2'd2
    } outcome_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RD_FWD  = 3'd1,
        ST_RD_LATE = 3'd2,
        ST_WR_DONE = 3'd3,
        ST_NOP     = 3'd4,
        ST_TRAP    = 3'd5
    } state_e;

endpackage

// File: rtl/spr_table.sv
module spr_table
    import spr_chk_pkg::*;
#(
    parameter int SPR_W    = 10,
    parameter int PMU_BASE = 776,
    parameter int PMU_CNT  = 8
) (
    input  logic [SPR_W-1:0] spr_num,
    output spr_attr_t        attr
);
    localparam int PMU_LAST = PMU_BASE + PMU_CNT - 1;

    logic in_pmu;
    assign in_pmu = (int'(spr_num) >= PMU_BASE) && (int'(spr_num) <= PMU_LAST);

    always_comb begin
        attr = '0;
        case (int'(spr_num))
            SPR_FIXUP, SPR_LINK, SPR_COUNT: begin
                attr.defined = 1'b1;
                attr.rd_user = 1'b1;  attr.wr_user = 1'b1;
                attr.rd_sup  = 1'b1;  attr.wr_sup  = 1'b1;
                attr.rd_hyp  = 1'b1;  attr.wr_hyp  = 1'b1;
            end
            SPR_TBASE: begin
                attr.defined = 1'b1;
                attr.rd_user = 1'b1;
                attr.rd_sup  = 1'b1;
                attr.rd_hyp  = 1'b1;
                attr.slow    = 1'b1;
            end
            SPR_DECR: begin
                attr.defined = 1'b1;
                attr.rd_sup  = 1'b1;  attr.wr_sup  = 1'b1;
                attr.rd_hyp  = 1'b1;  attr.wr_hyp  = 1'b1;
                attr.slow    = 1'b1;
            end
            SPR_SAVE0, SPR_SAVE1: begin
                attr.defined = 1'b1;
                attr.rd_sup  = 1'b1;  attr.wr_sup  = 1'b1;
                attr.rd_hyp  = 1'b1;  attr.wr_hyp  = 1'b1;
            end
            SPR_HSCR: begin
                attr.defined = 1'b1;
                attr.rd_hyp  = 1'b1;  attr.wr_hyp  = 1'b1;
            end
            default: begin
                if (in_pmu) begin
                    attr.defined = 1'b1;
                    attr.rd_user = 1'b1;
                    attr.rd_sup  = 1'b1;  attr.wr_sup  = 1'b1;
                    attr.rd_hyp  = 1'b1;  attr.wr_hyp  = 1'b1;
                    attr.pmu     = 1'b1;
                end
            end
        endcase
    end

endmodule

// File: rtl/spr_classify.sv
module spr_classify
    import spr_chk_pkg::*;
#(
    parameter int SPR_W = 10
) (
    input  logic [SPR_W-1:0] spr_num,
    input  logic             is_write,
    input  logic [1:0]       priv,
    input  logic             virt_trap_en,
    input  spr_attr_t        attr,
    output outcome_e         outcome
);
    localparam int RSV_N = 4;
    localparam int RSV_CODES [RSV_N] = '{0, 4, 5, 6};

    logic is_user, is_sup, is_hyp;
    logic rsv_hit, permit;

    assign is_user = (priv == 2'b00);
    assign is_sup  = (priv == 2'b01);
    assign is_hyp  = priv[1];

    always_comb begin
        rsv_hit = 1'b0;
        for (int i = 0; i < RSV_N; i++) begin
            if (int'(spr_num) == RSV_CODES[i]) rsv_hit = 1'b1;
        end
    end

    always_comb begin
        if (is_write)
            permit = is_user ? attr.wr_user : (is_sup ? attr.wr_sup : attr.wr_hyp);
        else
            permit = is_user ? attr.rd_user : (is_sup ? attr.rd_sup : attr.rd_hyp);
    end

    always_comb begin
        if (rsv_hit && !is_user)
            outcome = OUT_TRAP;
        else if (permit)
            outcome = OUT_EXEC;
        else if (is_user)
            outcome = OUT_TRAP;
        else if (is_hyp)
            outcome = virt_trap_en ? OUT_TRAP : OUT_NOP;
        else
            outcome = OUT_NOP;
    end

endmodule

// File: rtl/spr_irq_gate.sv
module spr_irq_gate (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] priv,
    input  logic       pending,
    input  logic       enable,
    input  logic       hv_disable,
    output logic       irq_valid
);
    logic masked;
    assign masked    = hv_disable && priv[1];
    assign irq_valid = pending && enable && !masked;

    // R10: the disable bit never masks in user state
    p_user_unmasked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && enable && priv == 2'b00) |-> irq_valid);

endmodule

// File: rtl/spr_access_check.sv
module spr_access_check
    import spr_chk_pkg::*;
#(
    parameter int SPR_W    = 10,
    parameter int PMU_BASE = 776,
    parameter int PMU_CNT  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_is_write,
    input  logic [SPR_W-1:0] req_spr,
    input  logic [1:0]       priv_mode,
    input  logic             virt_trap_en,
    input  logic             stall,
    input  logic             ext_irq_pending,
    input  logic             ext_irq_enable,
    input  logic             ext_irq_hv_dis,
    output logic             hv_emul_irq,
    output logic             gpr_wr_en,
    output logic             fwd_allow,
    output logic             ext_irq_valid
);
    spr_attr_t attr;
    outcome_e  outcome;
    state_e    state_q, state_d;

    spr_table #(.SPR_W(SPR_W), .PMU_BASE(PMU_BASE), .PMU_CNT(PMU_CNT)) u_table (
        .spr_num (req_spr),
        .attr    (attr)
    );

    spr_classify #(.SPR_W(SPR_W)) u_classify (
        .spr_num      (req_spr),
        .is_write     (req_is_write),
        .priv         (priv_mode),
        .virt_trap_en (virt_trap_en),
        .attr         (attr),
        .outcome      (outcome)
    );

    spr_irq_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .priv       (priv_mode),
        .pending    (ext_irq_pending),
        .enable     (ext_irq_enable),
        .hv_disable (ext_irq_hv_dis),
        .irq_valid  (ext_irq_valid)
    );

    always_comb begin
        state_d = ST_IDLE;
        if (req_valid && !stall) begin
            unique case (outcome)
                OUT_EXEC: begin
                    if (req_is_write)
                        state_d = ST_WR_DONE;
                    else if (attr.slow || attr.pmu)
                        state_d = ST_RD_LATE;
                    else
                        state_d = ST_RD_FWD;
                end
                OUT_NOP:  state_d = ST_NOP;
                OUT_TRAP: state_d = ST_TRAP;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        hv_emul_irq = 1'b0;
        gpr_wr_en   = 1'b0;
        fwd_allow   = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_RD_FWD:  begin gpr_wr_en = 1'b1; fwd_allow = 1'b1; end
            ST_RD_LATE: gpr_wr_en = 1'b1;
            ST_WR_DONE: ;
            ST_NOP:     ;
            ST_TRAP:    hv_emul_irq = 1'b1;
            default:    ;
        endcase
    end

    // R2: no request means quiet outputs next cycle
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!hv_emul_irq && !gpr_wr_en && !fwd_allow));

    // R3: stall suppresses the verdict
    p_stall_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (!hv_emul_irq && !gpr_wr_en && !fwd_allow));

    // R4: reserved numbers trap in privileged state
    p_rsv_trap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !stall && priv_mode != 2'b00 &&
         (req_spr == SPR_W'(0) || req_spr == SPR_W'(4) ||
          req_spr == SPR_W'(5) || req_spr == SPR_W'(6))) |=> hv_emul_irq);

    // R8: a write never enables the general-register write
    p_write_no_we_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_write) |=> !gpr_wr_en);

    // R9: slow and monitor registers never forward
    p_slow_nofwd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (attr.slow || attr.pmu)) |=> !fwd_allow);

endmodule

// File: tb/spr_access_check_bench.sv
module spr_access_check_bench;

    typedef struct {
        logic  irq;
        logic  we;
        logic  fwd;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_is_write = 1'b0;
    logic [9:0] req_spr = '0;
    logic [1:0] priv_mode = 2'b00;
    logic       virt_trap_en = 1'b0;
    logic       stall = 1'b0;
    logic       ext_irq_pending = 1'b0;
    logic       ext_irq_enable = 1'b0;
    logic       ext_irq_hv_dis = 1'b0;
    logic       hv_emul_irq, gpr_wr_en, fwd_allow, ext_irq_valid;

    int   n_run = 0;
    int   n_fail = 0;
    bit   finished = 0;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    spr_access_check u_spr_access_check (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid       (req_valid),
        .req_is_write    (req_is_write),
        .req_spr         (req_spr),
        .priv_mode       (priv_mode),
        .virt_trap_en    (virt_trap_en),
        .stall           (stall),
        .ext_irq_pending (ext_irq_pending),
        .ext_irq_enable  (ext_irq_enable),
        .ext_irq_hv_dis  (ext_irq_hv_dis),
        .hv_emul_irq     (hv_emul_irq),
        .gpr_wr_en       (gpr_wr_en),
        .fwd_allow       (fwd_allow),
        .ext_irq_valid   (ext_irq_valid)
    );

    // Permission model taken from the R11 table
    function automatic bit allowed(int n, bit wr, logic [1:0] p);
        bit u = (p == 2'b00);
        bit s = (p == 2'b01);
        if (n == 1 || n == 8 || n == 9) return 1;
        if (n == 268) return !wr;
        if (n == 22 || n == 26 || n == 27) return !u;
        if (n == 304) return !u && !s;
        if (n >= 776 && n <= 783) return wr ? !u : 1;
        return 0;
    endfunction

    // 0 execute, 1 no-op, 2 trap
    function automatic int verdict(int n, bit wr, logic [1:0] p, bit virt);
        bit rsv = (n == 0 || n == 4 || n == 5 || n == 6);
        if (rsv && p != 2'b00) return 2;
        if (allowed(n, wr, p)) return 0;
        if (p == 2'b00) return 2;
        if (p[1]) return virt ? 2 : 1;
        return 1;
    endfunction

    task automatic drive(input bit v, input bit wr, input int n, input logic [1:0] p,
                         input bit virt, input bit st, input string tag);
        exp_t e;
        int   vd;
        bit   ext_exp;
        @(negedge clk);
        req_valid    = v;
        req_is_write = wr;
        req_spr      = 10'(n);
        priv_mode    = p;
        virt_trap_en = virt;
        stall        = st;
        e.irq = 0; e.we = 0; e.fwd = 0; e.tag = tag;
        if (v && !st) begin
            vd = verdict(n, wr, p, virt);
            e.irq = (vd == 2);
            e.we  = (vd == 0) && !wr;
            e.fwd = e.we && !(n == 22 || n == 268 || (n >= 776 && n <= 783));
        end
        sb_q.push_back(e);
        #1;
        ext_exp = ext_irq_pending && ext_irq_enable && !(ext_irq_hv_dis && p[1]);
        n_run++;
        if (ext_irq_valid !== ext_exp) begin
            n_fail++;
            $display("FAIL R10: ext_irq_valid got %b expected %b", ext_irq_valid, ext_exp);
        end
    endtask

    // Monitor: one verdict per rising edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #5;
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                n_run++;
                if (hv_emul_irq !== e.irq || gpr_wr_en !== e.we || fwd_allow !== e.fwd) begin
                    n_fail++;
                    $display("FAIL %s: irq/we/fwd got %b%b%b expected %b%b%b", e.tag,
                             hv_emul_irq, gpr_wr_en, fwd_allow, e.irq, e.we, e.fwd);
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        n_run++;
        if (hv_emul_irq !== 0 || gpr_wr_en !== 0 || fwd_allow !== 0) begin
            n_fail++;
            $display("FAIL R1: reset outputs got %b%b%b expected 000",
                     hv_emul_irq, gpr_wr_en, fwd_allow);
        end

        drive(0, 0, 8, 2'b00, 0, 0, "R2");
        // executed reads and writes
        drive(1, 0, 8, 2'b00, 0, 0, "R8 R11");
        drive(1, 1, 8, 2'b00, 0, 0, "R8");
        drive(1, 0, 1, 2'b10, 0, 0, "R9");
        drive(1, 0, 26, 2'b01, 0, 0, "R11");
        drive(1, 1, 304, 2'b10, 0, 0, "R11");
        // reserved numbers in privileged state
        drive(1, 0, 0, 2'b01, 0, 0, "R4");
        drive(1, 0, 5, 2'b10, 0, 0, "R4");
        drive(1, 1, 6, 2'b01, 0, 0, "R4");
        drive(1, 1, 4, 2'b11, 0, 0, "R4");
        // user-state unimplemented
        drive(1, 0, 304, 2'b00, 0, 0, "R5");
        drive(1, 1, 268, 2'b00, 0, 0, "R5");
        drive(1, 0, 999, 2'b00, 0, 0, "R5");
        drive(1, 0, 22, 2'b00, 0, 0, "R5");
        drive(1, 0, 784, 2'b00, 0, 0, "R5");
        drive(1, 0, 775, 2'b00, 0, 0, "R5");
        // hypervisor undefined
        drive(1, 0, 500, 2'b10, 1, 0, "R6");
        drive(1, 0, 500, 2'b10, 0, 0, "R6");
        drive(1, 1, 268, 2'b10, 0, 0, "R6");
        drive(1, 1, 268, 2'b10, 1, 0, "R6");
        drive(1, 0, 500, 2'b11, 0, 0, "R6");
        // supervisor undefined
        drive(1, 0, 500, 2'b01, 1, 0, "R7");
        drive(1, 0, 304, 2'b01, 0, 0, "R7");
        // slow and monitor reads
        drive(1, 0, 268, 2'b00, 0, 0, "R9");
        drive(1, 0, 22, 2'b01, 0, 0, "R9");
        drive(1, 0, 776, 2'b00, 0, 0, "R9");
        drive(1, 0, 783, 2'b10, 0, 0, "R9");
        drive(1, 1, 780, 2'b01, 0, 0, "R9");
        // stall
        drive(1, 0, 5, 2'b10, 0, 1, "R3");
        drive(1, 0, 8, 2'b00, 0, 1, "R3");
        drive(1, 0, 8, 2'b00, 0, 0, "R2");
        drive(1, 0, 9, 2'b01, 0, 1, "R3");
        drive(0, 0, 0, 2'b10, 0, 0, "R2");

        // external interrupt gating
        ext_irq_pending = 1; ext_irq_enable = 1; ext_irq_hv_dis = 1;
        drive(0, 0, 0, 2'b00, 0, 0, "R10");
        drive(0, 0, 0, 2'b01, 0, 0, "R10");
        drive(0, 0, 0, 2'b10, 0, 0, "R10");
        drive(0, 0, 0, 2'b11, 0, 0, "R10");
        ext_irq_hv_dis = 0;
        drive(0, 0, 0, 2'b10, 0, 0, "R10");
        ext_irq_enable = 0;
        drive(0, 0, 0, 2'b00, 0, 0, "R10");
        ext_irq_enable = 1; ext_irq_pending = 0;
        drive(0, 0, 0, 2'b01, 0, 0, "R10");

        drive(0, 0, 0, 2'b00, 0, 0, "R2");
        repeat (3) @(posedge clk);
        #6;
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule